// File: doc/BRIEF.md
# Four-lane printhead shift loader

The loader holds a short burst of words for an inkjet printhead and sends them to it as four parallel serial lanes, with a shift clock that the block generates itself. A host fills the buffer one byte at a time while the block is idle and then pulses a start input. Only the low nibble of each byte is used, one bit per lane. Bit 0 drives the cyan lane, bit 1 the magenta lane, bit 2 the yellow lane and bit 3 the address lane. All four lanes advance together by one bit per shift clock.

The shift clock idles high. The printhead captures the lanes on each falling edge (CPOL=1, CPHA=0). The lanes change only when the clock is high, half a period ahead of the capturing edge, so setup and hold are equal. A fixed lead-in of system clocks comes before the first word, so that the first word lines up with the first clock period. The lane output-enable goes high when the burst starts and drops when it ends. A one-cycle done pulse marks the end of the burst. The clock period is a parameter, an even number of system clocks of at least two. At two, one word goes out every two system clocks, which is the fastest single-data-rate rate.

Top module: `phead_loader`

## Requirements
- R1: After reset, `sclk_o` is 1, `lanes_o` is 0, `lanes_oe_o` is 0 and `done_o` is 0.
- R2: A start pulse while idle produces exactly WORDS (default 40) falling edges of `sclk_o`, followed by one burst end.
- R3: At the k-th falling edge (k counted from 0), `lanes_o[i]` equals bit i of the byte last written to address k, for i from 0 to 3: bit 0 cyan, bit 1 magenta, bit 2 yellow, bit 3 address. Bits 7 to 4 of a written byte have no effect on any output.
- R4: During a burst, `sclk_o` stays low for DIV/2 cycles and high for DIV/2 cycles between falling edges. `lanes_o` changes only in a cycle where `sclk_o` is high, and it is stable across each falling edge.
- R5: If the start pulse is captured at clock edge 0, the first word appears at edge LEAD. The k-th falling edge of `sclk_o` follows edge LEAD+k*DIV+DIV/2. The burst ends at edge LEAD+WORDS*DIV.
- R6: `lanes_oe_o` rises at the edge that captures start and stays high for the whole burst. It falls at the burst end. While it is low, `lanes_o` is 0 and `sclk_o` is 1.
- R7: `done_o` is high for exactly one cycle, at the burst end, in the same cycle that `lanes_oe_o` falls.
- R8: A start pulse received during a burst is ignored: the burst keeps its length and its data.
- R9: A buffer write is ignored while a burst is busy, and a write to an address of WORDS or higher is ignored. Neither changes the data of the current burst or of later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_addr_i | input | 6 | Buffer write address |
| wr_data_i | input | 8 | Buffer write byte; low nibble holds the lane bits |
| start_i | input | 1 | Start a burst (honoured only while idle) |
| sclk_o | output | 1 | Shift clock, idles high, data captured on falling edge |
| lanes_o | output | 4 | Lane data: bit 0 cyan, bit 1 magenta, bit 2 yellow, bit 3 address |
| lanes_oe_o | output | 1 | Output-enable for the lane pads |
| done_o | output | 1 | One-cycle burst-complete pulse |

## Verification
The buffer is filled with random bytes whose high nibbles are also random, so any leak of bits 7 to 4 onto the lanes, or any swap of lane bits, shows up at the sampled falling edges. Two directed patterns complete the set. An alternating 0x5/0xA pattern tells a correct word order apart from an off-by-one word index. An all-ones word at only the first and last addresses separates a lead-in or end-of-burst miscount from correct alignment. One burst is disturbed by a start pulse and a buffer write in mid-burst. Another is preceded by an out-of-range write. In both, any change to the length, the timing or the data of that burst or the next one is caught.

// File: rtl/phead_pkg.sv
// Package: shared types for the printhead loader.
// Assumes nothing beyond standard SystemVerilog.
package phead_pkg;
    // Burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/phead_buf.sv
// Word buffer: stores the lane nibble of each written byte.
// Writes are accepted only when wr_ok is high and the address is in range.
// The read is combinational, indexed by the sequencer.
module phead_buf #(
    parameter int WORDS  = 40,
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANES-1:0]  rd_word
);
    logic [LANES-1:0] mem [WORDS];
    logic             in_range;
    logic             unused_hi;

    // The upper byte bits carry nothing for the lanes
    assign unused_hi = ^wr_data[BYTE_W-1:LANES];
    // Range check on the incoming address
    assign in_range  = (32'(wr_addr) < WORDS);

    // Store the low nibble of the byte
    always_ff @(posedge clk) begin
        if (wr_en && wr_ok && in_range)
            mem[IDX_W'(wr_addr)] <= wr_data[LANES-1:0];
    end

    // Per-lane read-out
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_word[g] = mem[rd_idx][g];
    end
endmodule

// File: rtl/phead_phase.sv
// Shift clock phase counter: counts the system clocks inside one
// word period of DIV cycles. It flags the end of the high half and
// the end of the period. Assumes DIV is even and at least 2.
module phead_phase #(
    parameter int DIV = 4,
    localparam int HALF  = DIV / 2,
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic half_end,
    output logic per_end
);
    logic [CNT_W-1:0] cnt;

    assign half_end = run && (cnt == CNT_W'(HALF - 1));
    assign per_end  = run && (cnt == CNT_W'(DIV - 1));

    // Advance the phase, wrap at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n || clear || per_end)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/phead_seq.sv
// Burst sequencer: lead-in counting, word indexing, and the registered
// clock, lane, enable and done outputs. The lanes change only together
// with a high shift clock. Assumes LEAD >= 1 and WORDS >= 1.
module phead_seq
    import phead_pkg::*;
#(
    parameter int WORDS = 40,
    parameter int LEAD  = 3,
    parameter int LANES = 4,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LEAD_W = $clog2(LEAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             half_end,
    input  logic             per_end,
    input  logic [LANES-1:0] rd_word,
    output logic [IDX_W-1:0] rd_idx,
    output logic             idle,
    output logic             run,
    output logic             run_enter,
    output logic             sclk,
    output logic [LANES-1:0] lanes,
    output logic             oe,
    output logic             done
);
    seq_state_t        state;
    logic [LEAD_W-1:0] lcnt;
    logic [IDX_W-1:0]  idx;
    logic              last_word;

    assign idle      = (state == ST_IDLE);
    assign run       = (state == ST_RUN);
    assign run_enter = (state == ST_LEAD) && (lcnt == LEAD_W'(LEAD - 1));
    assign last_word = (idx == IDX_W'(WORDS - 1));
    // Word to present next: first word on entry, else the following one
    assign rd_idx    = run_enter ? '0 : idx + 1'b1;

    // State, counters and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lcnt  <= '0;
            idx   <= '0;
            sclk  <= 1'b1;
            lanes <= '0;
            oe    <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LEAD;
                        lcnt  <= '0;
                        oe    <= 1'b1;
                    end
                end
                ST_LEAD: begin
                    lcnt <= lcnt + 1'b1;
                    if (run_enter) begin
                        state <= ST_RUN;
                        idx   <= '0;
                        lanes <= rd_word;
                        sclk  <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (half_end)
                        sclk <= 1'b0;
                    if (per_end) begin
                        sclk <= 1'b1;
                        if (last_word) begin
                            state <= ST_IDLE;
                            lanes <= '0;
                            oe    <= 1'b0;
                            done  <= 1'b1;
                        end else begin
                            idx   <= idx + 1'b1;
                            lanes <= rd_word;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phead_loader.sv
// Top: four-lane printhead shift loader. It ties together the word
// buffer, the phase counter and the burst sequencer. Assumes DIV is even
// and >= 2, LEAD >= 1, and that WORDS fits in the write address space.
module phead_loader #(
    parameter int WORDS  = 40,
    parameter int DIV    = 4,
    parameter int LEAD   = 3,
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              start_i,
    output logic              sclk_o,
    output logic [LANES-1:0]  lanes_o,
    output logic              lanes_oe_o,
    output logic              done_o
);
    logic [IDX_W-1:0] rd_idx;
    logic [LANES-1:0] rd_word;
    logic idle, run, run_enter, half_end, per_end;

    phead_buf #(.WORDS(WORDS), .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_buf (
        .clk(clk), .wr_en(wr_en_i), .wr_ok(idle), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    phead_phase #(.DIV(DIV)) u_phase (
        .clk(clk), .rst_n(rst_n), .clear(run_enter), .run(run),
        .half_end(half_end), .per_end(per_end)
    );

    phead_seq #(.WORDS(WORDS), .LEAD(LEAD), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_i), .half_end(half_end),
        .per_end(per_end), .rd_word(rd_word), .rd_idx(rd_idx), .idle(idle),
        .run(run), .run_enter(run_enter), .sclk(sclk_o), .lanes(lanes_o),
        .oe(lanes_oe_o), .done(done_o)
    );
endmodule

// File: rtl/phead_loader_chk.sv
// Checker: timing and enable relations of the loader outputs.
// Bound to every phead_loader instance.
module phead_loader_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_o,
    input logic [LANES-1:0] lanes_o,
    input logic             lanes_oe_o,
    input logic             done_o
);
    // R4: lanes move only while the shift clock is high
    assert_lanes_move_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_o != $past(lanes_o)) |-> sclk_o);

    // R4: data is stable across a capturing edge
    assert_stable_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> $stable(lanes_o));

    // R6: disabled bus keeps the clock idle high and the lanes at zero
    assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lanes_oe_o |-> (sclk_o && lanes_o == '0));

    // R7: done is a single-cycle pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done comes with the release of the bus
    assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(lanes_oe_o) && !lanes_oe_o));
endmodule

bind phead_loader phead_loader_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .lanes_o(lanes_o),
    .lanes_oe_o(lanes_oe_o), .done_o(done_o)
);

// File: tb/phead_loader_tb_top.sv
// Bench for phead_loader: random and directed buffer contents, plus
// mid-burst disturbance, checked against a bench-side model.
module phead_loader_tb_top;
    localparam int WORDS = 40;
    localparam int DIV   = 4;
    localparam int LEAD  = 3;
    localparam int HALF  = DIV / 2;
    localparam int BURST = LEAD + WORDS * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic       sclk, oe, done;
    logic [3:0] lanes;

    int checks = 0;
    int failures = 0;
    logic [3:0] model [WORDS];

    always #5 clk = ~clk;

    phead_loader #(.WORDS(WORDS), .DIV(DIV), .LEAD(LEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .start_i(start), .sclk_o(sclk), .lanes_o(lanes),
        .lanes_oe_o(oe), .done_o(done)
    );

    // Expected lane nibble for a byte: low four bits only
    function automatic logic [3:0] lane_of(input logic [7:0] b);
        return b[3:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One buffer write, applied while idle; the model follows the requirement
    task automatic put(input int a, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < WORDS) model[a] = lane_of(b);
    endtask

    // Run one burst and check it; poke = start + write in mid-burst
    task automatic burst(input bit poke, input string tag);
        int falls = 0, done_at = -1, low_run = 0, high_run = 0, s = 0;
        int bad = 0, tim_bad = 0;
        logic prev;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(oe === 1'b1, "R6", oe, 1);
        prev = sclk;
        while (s <= BURST + 2) begin
            if (poke && s == 60) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 6'd5; wr_data = ~{4'h0, model[5]};
            end else if (poke && s == 61) begin
                start = 1'b0; wr_en = 1'b0;
            end
            if (prev && !sclk) begin
                if (falls < WORDS) begin
                    check(lanes === model[falls], tag, lanes, model[falls]);
                    if (lanes !== model[falls]) bad++;
                end
                if (s != LEAD + falls * DIV + HALF) tim_bad++;
                if (falls > 0 && high_run != HALF) tim_bad++;
                falls++;
            end
            if (!sclk) begin low_run++; high_run = 0; end
            else begin
                if (!prev && low_run != HALF) tim_bad++;
                low_run = 0;
                if (s >= LEAD) high_run++;
            end
            if (done) begin
                if (done_at >= 0) tim_bad++;
                done_at = s;
                check(oe === 1'b0, "R7", oe, 0);
            end
            if (s > 0 && s < BURST) check(oe === 1'b1, "R6", oe, 1);
            prev = sclk;
            @(negedge clk);
            s++;
        end
        check(falls == WORDS, poke ? "R8" : "R2", falls, WORDS);
        check(done_at == BURST, "R5", done_at, BURST);
        check(tim_bad == 0, "R4", tim_bad, 0);
        check(oe === 1'b0 && lanes === 4'h0 && sclk === 1'b1, "R6", {oe, lanes, sclk}, 1);
        if (poke) check(bad == 0, "R9", bad, 0);
    endtask

    // Watchdog
    initial begin
        #1500000;
        failures++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7177));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sclk === 1'b1, "R1", sclk, 1);
        check(lanes === 4'h0, "R1", lanes, 0);
        check(oe === 1'b0, "R1", oe, 0);
        check(done === 1'b0, "R1", done, 0);

        // R3: random bytes, high nibble random too
        for (int i = 0; i < WORDS; i++) put(i, 8'($urandom));
        burst(1'b0, "R3");

        // R3: alternating pattern exposes word index slips
        for (int i = 0; i < WORDS; i++) put(i, (i % 2) ? 8'hFA : 8'h05);
        burst(1'b0, "R3");

        // R5: ones only at first and last word
        for (int i = 0; i < WORDS; i++) put(i, 8'hF0);
        put(0, 8'h0F); put(WORDS - 1, 8'h0F);
        burst(1'b0, "R5");

        // R8/R9: random data, start and write during the burst
        for (int i = 0; i < WORDS; i++) put(i, 8'($urandom));
        burst(1'b1, "R8");
        burst(1'b0, "R9");

        // R9: out-of-range writes must not alias into the buffer
        put(WORDS, 8'hFF); put(63, 8'hAA); put(WORDS + 8, 8'h55);
        burst(1'b0, "R9");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule